// File: doc/BRIEF.md
# Stalled-Thread Instruction Parking Buffer

This block gives each hardware thread of a multithreaded out-of-order core a small private buffer. It parks instructions that belong to a thread waiting on a long memory access, so that they leave the shared instruction queue without being squashed. An instruction is parked when it arrives on the issue path and meets three conditions: its thread is marked stalled, the instruction is not ready, and that thread's buffer is not currently replaying. Up to `IN_W` issue slots are examined per cycle, and slot 0 is the oldest.

When the thread's pending load returns, the buffer sends its parked instructions back into the instruction queue, oldest first. For as long as a replay is in progress, the block asks rename to hold off its own path into the queue. Each cycle the replay is limited by the queue room the core reports and by the dispatch width `OUT_W`. Only one thread replays at a time, and the lowest thread index wins.

An instruction can find its thread's buffer full. In that case the block requests a flush of that thread starting at that instruction, and it discards everything the thread had parked.

Each thread lane runs a three-state machine:

- **IDLE**: the lane is empty.
- **HOLD**: the lane holds parked instructions.
- **DRAIN**: the lane is replaying.

The lane moves between states as follows:

- **park** (IDLE→HOLD): at least one instruction is accepted.
- **park-and-wake** (IDLE→DRAIN): instructions are accepted in the same cycle as the load return.
- **wake** (HOLD→DRAIN): the load returns.
- **overflow** (HOLD/IDLE→IDLE): an instruction finds the lane full; the contents are discarded and a flush is requested.
- **empty** (DRAIN→IDLE): the last entry is dispatched.

Top module: `stall_park_buf`

## Requirements
- R1: After reset, `disp_vld`, `flush_vld` and `rename_hold` are all 0, and every lane is empty.
- R2: An issue slot is parked in lane t only when all of the following hold: `iss_vld` is 1, `stall_mask[t]` is 1, `iss_rdy` is 0, `iss_tid` equals t, and lane t is not replaying. Any other slot is not held, so it never appears in a later replay.
- R3: Up to `IN_W` slots may be parked in one cycle. Slot i is treated as older than slot i+1, where slot i occupies bits `[i*DW +: DW]` of `iss_inst`.
- R4: A load return on `ld_done[t]` while lane t holds entries starts a replay from the next cycle. The same applies when entries are parked in the same cycle as the return. `rename_hold` is 1 in every cycle in which some lane is replaying.
- R5: A replay sends entries oldest first. Entry j is on `disp_inst[j*DW +: DW]`, and the valid entries are `disp_vld` bits 0..k-1, where k = min(`OUT_W`, `dq_room`, entries left). Values of `dq_room` above `OUT_W` count as `OUT_W`.
- R6: When several lanes are replaying, only the lowest-index one dispatches, and `disp_tid` gives its index.
- R7: When a parked slot finds its lane holding `DEPTH` entries, two things happen in the next cycle: `flush_vld[t]` is 1 for one cycle, and `flush_inst[t*DW +: DW]` carries that slot's instruction. The lane's contents, and any later slot of the same cycle, are discarded.
- R8: A load return to an empty lane has no effect. Instructions offered to a lane while it is replaying are not parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_mask | input | NT | Per-thread stalled marker |
| iss_vld | input | IN_W | Issue slot valid |
| iss_tid | input | IN_W*TW | Thread id of each slot |
| iss_rdy | input | IN_W | Slot instruction is ready to issue |
| iss_inst | input | IN_W*DW | Instruction payload of each slot |
| ld_done | input | NT | Stalling load returned, per thread |
| dq_room | input | OWB | Instruction-queue entries free this cycle |
| disp_vld | output | OUT_W | Replay slot valid |
| disp_tid | output | TW | Thread of the replaying lane |
| disp_inst | output | OUT_W*DW | Replayed instructions, oldest in slot 0 |
| rename_hold | output | 1 | Rename path must yield to replay |
| flush_vld | output | NT | Overflow flush request, per thread |
| flush_inst | output | NT*DW | Instruction the flush starts at, per thread |

## Verification
Parking is tried with slots that fail each acceptance condition in turn: a ready instruction, an unstalled thread, a wrong thread id, and a lane that is replaying. This separates the acceptance conditions from one another and from the slot ordering. Replay is swept over every fill level from 1 to `DEPTH` against every queue-room value, including zero and values above `OUT_W`. The sweep separates the room clamp from the width limit and from the count of entries left. Overflow is driven once on the older slot and once on the younger slot of a cycle, which shows that the flush names the first instruction that did not fit. Two lanes are woken in the same cycle to expose the lowest-index arbitration.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;

    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,
        LANE_HOLD  = 2'd1,
        LANE_DRAIN = 2'd2
    } lane_state_t;

endpackage

// File: rtl/sb_ring.sv
`timescale 1ns/1ps
module sb_ring #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int IN_W  = 2,
    parameter int OUT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [$clog2(IN_W+1)-1:0]  wr_n,
    input  logic [IN_W*DW-1:0]     wr_data,
    input  logic [$clog2(OUT_W+1)-1:0] rd_n,
    output logic [OUT_W*DW-1:0]    rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] head;
    logic [AW-1:0] tail;

    function automatic logic [AW-1:0] ptr_add(input logic [AW-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return AW'(s);
    endfunction

    always_ff @(posedge clk) begin
        for (int i = 0; i < IN_W; i++) begin
            if (!clr && (i < int'(wr_n)))
                mem[ptr_add(tail, i)] <= wr_data[i*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= ptr_add(head, int'(rd_n));
            tail  <= ptr_add(tail, int'(wr_n));
            count <= CW'(int'(count) + int'(wr_n) - int'(rd_n));
        end
    end

    always_comb begin
        for (int j = 0; j < OUT_W; j++)
            rd_data[j*DW +: DW] = mem[ptr_add(head, j)];
    end

    AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);  // R3
    AST_RING_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_n) <= int'(count));  // R5

endmodule

// File: rtl/sb_lane.sv
`timescale 1ns/1ps
module sb_lane
    import sb_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int IN_W  = 2,
    parameter int OUT_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IN_W-1:0]            take,
    input  logic [IN_W*DW-1:0]         slot_data,
    input  logic                       ld_done,
    input  logic                       grant,
    input  logic [$clog2(OUT_W+1)-1:0] room,
    output lane_state_t                state_o,
    output logic [OUT_W*DW-1:0]        rd_data,
    output logic [$clog2(OUT_W+1)-1:0] pop_n,
    output logic                       flush_vld,
    output logic [DW-1:0]              flush_inst
);
    localparam int IWB = $clog2(IN_W + 1);
    localparam int OWB = $clog2(OUT_W + 1);
    localparam int CW  = $clog2(DEPTH + 1);

    lane_state_t       state_q, state_d;
    logic [CW-1:0]     count;
    logic [IWB-1:0]    rank;
    logic [IWB-1:0]    wr_n;
    logic [IN_W*DW-1:0] wr_data;
    logic              ovf;
    logic [DW-1:0]     ovf_data;
    int                count_after;

    sb_ring #(.DW(DW), .DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ovf),
        .wr_n    (wr_n),
        .wr_data (wr_data),
        .rd_n    (pop_n),
        .rd_data (rd_data),
        .count   (count)
    );

    // Acceptance in slot order; first slot that does not fit triggers overflow.
    always_comb begin
        ovf      = 1'b0;
        ovf_data = '0;
        wr_data  = '0;
        rank     = '0;
        if (state_q != LANE_DRAIN) begin
            for (int i = 0; i < IN_W; i++) begin
                if (take[i] && !ovf) begin
                    if (int'(count) + int'(rank) < DEPTH) begin
                        wr_data[int'(rank)*DW +: DW] = slot_data[i*DW +: DW];
                        rank = rank + IWB'(1);
                    end else begin
                        ovf      = 1'b1;
                        ovf_data = slot_data[i*DW +: DW];
                    end
                end
            end
        end
        wr_n = ovf ? '0 : rank;
    end

    // Replay amount: bounded by granted room and remaining entries.
    always_comb begin
        pop_n = '0;
        if (state_q == LANE_DRAIN && grant) begin
            if (int'(room) < int'(count)) pop_n = room;
            else                          pop_n = OWB'(count);
        end
        count_after = ovf ? 0 : int'(count) + int'(wr_n) - int'(pop_n);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_IDLE: begin
                if (ovf)            state_d = LANE_IDLE;
                else if (wr_n != '0) state_d = ld_done ? LANE_DRAIN : LANE_HOLD;
                else                state_d = LANE_IDLE;
            end
            LANE_HOLD: begin
                if (ovf)          state_d = LANE_IDLE;
                else if (ld_done) state_d = LANE_DRAIN;
                else              state_d = LANE_HOLD;
            end
            LANE_DRAIN: begin
                if (count_after == 0) state_d = LANE_IDLE;
                else                  state_d = LANE_DRAIN;
            end
            default: state_d = LANE_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LANE_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_vld  <= 1'b0;
            flush_inst <= '0;
        end else begin
            flush_vld <= ovf;
            if (ovf) flush_inst <= ovf_data;
        end
    end

    assign state_o = state_q;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld |-> (count == '0 && state_q == LANE_IDLE));  // R7
    AST_DRAIN_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_DRAIN) |=> (count <= $past(count)));  // R8
    AST_HOLD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LANE_IDLE) |-> (count != '0));  // R4
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_IDLE) |-> (count == '0));  // R1

endmodule

// File: rtl/sb_pick.sv
`timescale 1ns/1ps
module sb_pick #(
    parameter int NT = 2,
    parameter int TW = 1
) (
    input  logic [NT-1:0] req,
    output logic [NT-1:0] gnt,
    output logic [TW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int t = NT - 1; t >= 0; t--) begin
            if (req[t]) begin
                gnt    = '0;
                gnt[t] = 1'b1;
                idx    = TW'(t);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/stall_park_buf.sv
`timescale 1ns/1ps
module stall_park_buf
    import sb_pkg::*;
#(
    parameter int NT    = 2,
    parameter int DEPTH = 8,
    parameter int IN_W  = 2,
    parameter int OUT_W = 2,
    parameter int DW    = 16,
    localparam int TW   = (NT > 1) ? $clog2(NT) : 1,
    localparam int OWB  = $clog2(OUT_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NT-1:0]       stall_mask,
    input  logic [IN_W-1:0]     iss_vld,
    input  logic [IN_W*TW-1:0]  iss_tid,
    input  logic [IN_W-1:0]     iss_rdy,
    input  logic [IN_W*DW-1:0]  iss_inst,
    input  logic [NT-1:0]       ld_done,
    input  logic [OWB-1:0]      dq_room,
    output logic [OUT_W-1:0]    disp_vld,
    output logic [TW-1:0]       disp_tid,
    output logic [OUT_W*DW-1:0] disp_inst,
    output logic                rename_hold,
    output logic [NT-1:0]       flush_vld,
    output logic [NT*DW-1:0]    flush_inst
);
    lane_state_t          lane_st  [NT];
    logic [OUT_W*DW-1:0]  lane_rd  [NT];
    logic [OWB-1:0]       lane_pop [NT];
    logic [NT-1:0]        drain_req;
    logic [NT-1:0]        gnt;
    logic [TW-1:0]        gidx;
    logic                 any_drain;
    logic [OWB-1:0]       room_c;

    assign room_c = (int'(dq_room) > OUT_W) ? OWB'(OUT_W) : dq_room;

    for (genvar t = 0; t < NT; t++) begin : g_lane
        logic [IN_W-1:0] take;
        always_comb begin
            for (int i = 0; i < IN_W; i++)
                take[i] = iss_vld[i] && stall_mask[t] && !iss_rdy[i]
                          && (iss_tid[i*TW +: TW] == TW'(t));
        end

        sb_lane #(.DW(DW), .DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (take),
            .slot_data  (iss_inst),
            .ld_done    (ld_done[t]),
            .grant      (gnt[t]),
            .room       (room_c),
            .state_o    (lane_st[t]),
            .rd_data    (lane_rd[t]),
            .pop_n      (lane_pop[t]),
            .flush_vld  (flush_vld[t]),
            .flush_inst (flush_inst[t*DW +: DW])
        );

        assign drain_req[t] = (lane_st[t] == LANE_DRAIN);
    end

    sb_pick #(.NT(NT), .TW(TW)) u_pick (
        .req (drain_req),
        .gnt (gnt),
        .idx (gidx),
        .any (any_drain)
    );

    always_comb begin
        disp_inst = lane_rd[gidx];
        disp_tid  = gidx;
        for (int j = 0; j < OUT_W; j++)
            disp_vld[j] = any_drain && (j < int'(lane_pop[gidx]));
    end

    assign rename_hold = any_drain;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));  // R6
    AST_DISP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(disp_vld) <= int'(room_c));  // R5
    AST_DISP_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|disp_vld) |-> rename_hold);  // R4
    AST_NO_FLUSH_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flush_vld & drain_req)) |-> 1'b0);  // R8

endmodule

// File: tb/stall_park_buf_test.sv
`timescale 1ns/1ps
module stall_park_buf_test;
    localparam int NT = 2, DEPTH = 8, IN_W = 2, OUT_W = 2, DW = 16, TW = 1, OWB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0]       stall_mask = '0;
    logic [IN_W-1:0]     iss_vld = '0;
    logic [IN_W*TW-1:0]  iss_tid = '0;
    logic [IN_W-1:0]     iss_rdy = '0;
    logic [IN_W*DW-1:0]  iss_inst = '0;
    logic [NT-1:0]       ld_done = '0;
    logic [OWB-1:0]      dq_room = '0;
    logic [OUT_W-1:0]    disp_vld;
    logic [TW-1:0]       disp_tid;
    logic [OUT_W*DW-1:0] disp_inst;
    logic                rename_hold;
    logic [NT-1:0]       flush_vld;
    logic [NT*DW-1:0]    flush_inst;

    always #2.5 clk = ~clk;

    stall_park_buf uut (
        .clk(clk), .rst_n(rst_n), .stall_mask(stall_mask), .iss_vld(iss_vld),
        .iss_tid(iss_tid), .iss_rdy(iss_rdy), .iss_inst(iss_inst), .ld_done(ld_done),
        .dq_room(dq_room), .disp_vld(disp_vld), .disp_tid(disp_tid),
        .disp_inst(disp_inst), .rename_hold(rename_hold), .flush_vld(flush_vld),
        .flush_inst(flush_inst)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    string tag = "R1";

    logic [DW-1:0] mq [NT][DEPTH];
    int            mn  [NT];
    int            mst [NT];   // 0 idle, 1 hold, 2 drain
    bit            mfl [NT];
    logic [DW-1:0] mfd [NT];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s/%s: actual %0h expected %0h", tag, req, act, exp);
        end
    endtask

    task automatic cyc(input logic [NT-1:0] stl, input logic [IN_W-1:0] v,
                       input logic [IN_W-1:0] tid, input logic [IN_W-1:0] rdy,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                       input logic [NT-1:0] ld, input int room);
        int g, k, rc;
        logic [DW-1:0] dd [IN_W];
        @(negedge clk);
        stall_mask = stl; iss_vld = v; iss_tid = tid; iss_rdy = rdy;
        iss_inst = {d1, d0}; ld_done = ld; dq_room = OWB'(room);
        dd[0] = d0; dd[1] = d1;
        #1;
        g = -1;
        for (int t = 0; t < NT; t++) if (mst[t] == 2 && g < 0) g = t;
        rc = (room > OUT_W) ? OUT_W : room;
        k = 0;
        if (g >= 0) k = (rc < mn[g]) ? rc : mn[g];
        for (int j = 0; j < OUT_W; j++) begin
            chk(disp_vld[j] == (j < k), "R5 disp_vld", 32'(disp_vld), 32'(k));
            if (j < k)
                chk(disp_inst[j*DW +: DW] == mq[g][j], "R5 order",
                    32'(disp_inst[j*DW +: DW]), 32'(mq[g][j]));
        end
        if (k > 0) chk(int'(disp_tid) == g, "R6 disp_tid", 32'(disp_tid), 32'(g));
        chk(rename_hold == (g >= 0), "R4 rename_hold", 32'(rename_hold), 32'(g >= 0));
        for (int t = 0; t < NT; t++) begin
            chk(flush_vld[t] == mfl[t], "R7 flush_vld", 32'(flush_vld[t]), 32'(mfl[t]));
            if (mfl[t])
                chk(flush_inst[t*DW +: DW] == mfd[t], "R7 flush_inst",
                    32'(flush_inst[t*DW +: DW]), 32'(mfd[t]));
        end
        // model update for the coming edge
        for (int t = 0; t < NT; t++) begin
            bit ovf;
            ovf = 0;
            if (mst[t] == 2) begin
                if (t == g) begin
                    for (int j = 0; j + k < DEPTH; j++) mq[t][j] = mq[t][j+k];
                    mn[t] -= k;
                end
                if (mn[t] == 0) mst[t] = 0;
            end else begin
                for (int i = 0; i < IN_W; i++) begin
                    if (v[i] && stl[t] && !rdy[i] && (int'(tid[i]) == t) && !ovf) begin
                        if (mn[t] < DEPTH) begin
                            mq[t][mn[t]] = dd[i];
                            mn[t]++;
                        end else begin
                            ovf = 1; mfd[t] = dd[i]; mn[t] = 0;
                        end
                    end
                end
                if (ovf)        mst[t] = 0;
                else if (mn[t] > 0) mst[t] = ld[t] ? 2 : 1;
                else            mst[t] = 0;
            end
            mfl[t] = ovf;
        end
    endtask

    task automatic idle(input int n, input int room);
        for (int i = 0; i < n; i++) cyc('0, '0, '0, '0, '0, '0, '0, room);
    endtask

    // fill lane t with n entries (two per cycle), base value b, wake on last
    task automatic fill(input int t, input int n, input logic [DW-1:0] b, input bit wake);
        int s;
        logic [NT-1:0] sm, lw;
        logic [IN_W-1:0] tt;
        sm = '0; sm[t] = 1'b1; tt = {IN_W{1'(t)}};
        s = 0;
        while (s < n) begin
            lw = '0;
            if (wake && s + 2 >= n) lw[t] = 1'b1;
            if (n - s >= 2) cyc(sm, 2'b11, tt, 2'b00, b + DW'(s), b + DW'(s + 1), lw, 0);
            else            cyc(sm, 2'b01, tt, 2'b00, b + DW'(s), '0, lw, 0);
            s += 2;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin mn[t] = 0; mst[t] = 0; mfl[t] = 0; mfd[t] = '0; end
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(disp_vld == '0, "R1 disp_vld", 32'(disp_vld), 0);
        chk(flush_vld == '0, "R1 flush_vld", 32'(flush_vld), 0);
        chk(rename_hold == 1'b0, "R1 rename_hold", 32'(rename_hold), 0);
        rst_n = 1'b1;
        idle(2, 2);

        // R2: acceptance filtering; R3: slot order within a cycle
        tag = "R2";
        cyc(2'b01, 2'b11, 2'b00, 2'b00, 16'h100, 16'h101, 2'b00, 0);
        cyc(2'b01, 2'b11, 2'b00, 2'b10, 16'h102, 16'h103, 2'b00, 0);
        cyc(2'b01, 2'b11, 2'b10, 2'b00, 16'h104, 16'h105, 2'b00, 0);
        cyc(2'b00, 2'b11, 2'b00, 2'b00, 16'h106, 16'h107, 2'b00, 0);
        cyc(2'b01, 2'b01, 2'b00, 2'b00, 16'h108, 16'h0,   2'b00, 0);
        // R4: wake, then R5 drain with varied room; R8 offers during drain
        tag = "R4";
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 2'b01, 0);
        tag = "R5";
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 2'b00, 1);
        tag = "R8";
        cyc(2'b01, 2'b11, 2'b00, 2'b00, 16'h1F0, 16'h1F1, 2'b00, 0);
        cyc(2'b01, 2'b11, 2'b00, 2'b00, 16'h1F2, 16'h1F3, 2'b00, 3);
        tag = "R5";
        idle(3, 2);
        // R8: load return to an empty lane
        tag = "R8";
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 2'b10, 2);
        idle(2, 2);

        // R7: overflow on the older slot
        tag = "R7";
        fill(1, 8, 16'h200, 0);
        cyc(2'b10, 2'b11, 2'b11, 2'b00, 16'h208, 16'h209, 2'b00, 0);
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 2'b10, 2);
        idle(2, 2);
        // R7: overflow on the younger slot discards the whole lane
        fill(1, 7, 16'h300, 0);
        cyc(2'b10, 2'b11, 2'b11, 2'b00, 16'h307, 16'h308, 2'b00, 0);
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 2'b10, 2);
        idle(2, 2);

        // R6: two lanes woken together; lowest index first
        tag = "R6";
        fill(1, 3, 16'h410, 0);
        fill(0, 3, 16'h400, 0);
        cyc(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 2'b11, 2);
        idle(6, 2);

        // R3: park-and-wake in the same cycle
        tag = "R3";
        cyc(2'b01, 2'b11, 2'b00, 2'b00, 16'h500, 16'h501, 2'b01, 0);
        idle(3, 1);

        // R5: sweep of fill level against queue room
        tag = "R5";
        for (int n = 1; n <= DEPTH; n++) begin
            for (int r = 0; r <= 3; r++) begin
                int c;
                fill(n % 2, n, DW'(16'h1000 + n * 16 + r * 256), 1);
                c = 0;
                while ((mst[n % 2] != 0) && c < 20) begin
                    cyc('0, '0, '0, '0, '0, '0, '0, (r == 0 && c < 2) ? 0 : ((r == 0) ? 2 : r));
                    c++;
                end
                idle(1, 2);
            end
        end

        idle(2, 2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule